// File: doc/BRIEF.md
# Buffered Serial Flash Command Shifter

This block lets host software issue any serial flash command without the hardware knowing what the command means. Software loads a transmit buffer of 32-bit words. The first word holds the opcode and any flash address, and any payload follows in the next words. Software then writes a length code to a control register. The engine drives the whole stream out MSB-first on a four-wire serial interface: clock, active-low select, data out and data in. While it does so, it records every returned data-in bit into a separate receive buffer. Because the length is given in groups of eight serial clocks, status polls, reads and page programs all use the same mechanism.

The host port is a plain synchronous port with a 32-bit address and 32-bit data. A write takes effect on the clock edge where it is sampled. Read data appears on the edge after the address is presented. Software polls the busy bit in the control register until it clears, then reads the results from the receive buffer.

Top module: `spi_cmd_buffer`

## Requirements
- R1: After reset the select output is 1, the serial clock is 0, the busy bit reads 0, and every word of both buffers reads 0.
- R2: Host addresses 0x1000 to 0x107F map to the 128-word transmit buffer, with word i at 0x1000+i. A host write there stores the 32-bit data, and a host read returns it one cycle later.
- R3: A host write to address 0x1 while idle starts a transfer of exactly (N+1)*8 serial clock pulses, where N is write data bits 8..0. The select line falls on the edge that samples the write and stays low for DIV system clocks before the first rising serial edge. It rises on the same edge as the last falling serial edge, DIV/2 system clocks after the last rising one.
- R4: A read of address 0x1 returns the busy flag in bit 0 and 0 in all other bits. Busy is 1 from the sampled start write until the select line rises again.
- R5: Serial bit k of a transfer is bit 31-(k mod 32) of transmit word k/32, so word 0 bit 31 goes first. The data-out line changes only while the serial clock is low.
- R6: The data-in level is sampled on each rising serial edge. Received bit k is stored in receive word k/32 at bit 31-(k mod 32). Host addresses 0x1080 to 0x10FF read receive words 0 to 127.
- R7: Receive-buffer bits at positions k at or beyond (N+1)*8 keep the values they held before the transfer.
- R8: Host writes to 0x1080 to 0x10FF have no effect on any buffer word.
- R9: A start write that arrives while busy is ignored, and the running transfer keeps its original length.
- R10: The serial clock period is DIV system clocks, with DIV/2 high and DIV/2 low. DIV is an even parameter with a default of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Host word address |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Several properties are checked on every cycle:
- The serial clock stays low whenever the select line is high.
- The select line rises only together with a falling serial edge.
- Data out holds steady while the clock is high.
- Busy matches the select line.
- A start write during a transfer leaves the loaded length unchanged.
- The bit counter stays below the length.

Only the scenarios can show the rest: the exact number of pulses, the lead time and the period, the MSB-first order from the buffer, the bit placement in the receive buffer, and that bits beyond a short transfer and writes to the read-only window leave stored words untouched.

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WORDS = 128,
  parameter int LEN_W = 9,
  parameter int DIV = 4,
  parameter logic [AW-1:0] CTRL_ADDR = 32'h1,
  parameter logic [AW-1:0] WBUF_BASE = 32'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int WB = $clog2(DW);
  localparam int TOT_W = LEN_W + 4;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV / 2 - 1);
  localparam logic [AW-1:0] WBUF_END = WBUF_BASE + AW'(WORDS);
  localparam logic [AW-1:0] RBUF_END = WBUF_END + AW'(WORDS);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW} st_t;

  st_t              st;
  logic [DW-1:0]    wbuf [WORDS];
  logic [DW-1:0]    rbuf [WORDS];
  logic [TOT_W-1:0] len_bits;
  logic [TOT_W-1:0] bcnt;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    rd_next;

  wire              busy   = (st != S_IDLE);
  wire [IDX_W-1:0]  idx    = bus_addr[IDX_W-1:0];
  wire              in_w   = (bus_addr >= WBUF_BASE) && (bus_addr < WBUF_END);
  wire              in_r   = (bus_addr >= WBUF_END) && (bus_addr < RBUF_END);
  wire              start  = bus_we && (bus_addr == CTRL_ADDR);
  wire [IDX_W-1:0]  widx   = bcnt[WB+IDX_W-1:WB];
  wire [WB-1:0]     bpos   = ~bcnt[WB-1:0];
  wire              last   = (bcnt == len_bits - TOT_W'(1));

  assign spi_mosi = busy ? wbuf[widx][bpos] : 1'b0;

  always_comb begin
    if (bus_addr == CTRL_ADDR) rd_next = {{(DW-1){1'b0}}, busy};
    else if (in_w)             rd_next = wbuf[idx];
    else if (in_r)             rd_next = rbuf[idx];
    else                       rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      len_bits  <= '0;
      bcnt      <= '0;
      cnt       <= '0;
      spi_sck   <= 1'b0;
      spi_cs_n  <= 1'b1;
      bus_rdata <= '0;
      for (int i = 0; i < WORDS; i++) begin
        wbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else begin
      bus_rdata <= rd_next;
      if (bus_we && in_w) wbuf[idx] <= bus_wdata;
      case (st)
        S_IDLE: if (start) begin
          len_bits <= TOT_W'({bus_wdata[LEN_W-1:0], 3'b000}) + TOT_W'(8);
          bcnt     <= '0;
          cnt      <= '0;
          spi_cs_n <= 1'b0;
          st       <= S_LEAD;
        end
        S_LEAD: if (cnt == LEAD_LAST) begin
          cnt <= '0;
          spi_sck <= 1'b1;
          rbuf[widx][bpos] <= spi_miso;
          st <= S_HIGH;
        end else cnt <= cnt + 1'b1;
        S_HIGH: if (cnt == HALF_LAST) begin
          cnt <= '0;
          spi_sck <= 1'b0;
          if (last) begin
            spi_cs_n <= 1'b1;
            st <= S_IDLE;
          end else begin
            bcnt <= bcnt + 1'b1;
            st <= S_LOW;
          end
        end else cnt <= cnt + 1'b1;
        default: if (cnt == HALF_LAST) begin
          cnt <= '0;
          spi_sck <= 1'b1;
          rbuf[widx][bpos] <= spi_miso;
          st <= S_HIGH;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assert_sck_low_when_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_cs_rise_with_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $fell(spi_sck));
  assert_bcnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < len_bits));
  assert_busy_tracks_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n);
  assert_mosi_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_bits));
endmodule

// File: tb/spi_cmd_buffer_bench.sv
module spi_cmd_buffer_bench;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  spi_cmd_buffer #(.DIV(DIV)) u_spi_cmd_buffer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  int total = 0, failed = 0, cyc = 0, seed = 1;
  int falls = 0, fall_base = 0, rises = 0, mosi_err = 0, per_err = 0, lead_err = 0;
  int last_rise = 0, cs_fall_cyc = 0;
  bit finished = 0;
  logic exp_q[$];
  logic [31:0] wm [128];
  logic [31:0] rm [128];

  function automatic logic sbit(int k, int s);
    int h;
    h = k * s + (k >> 3) * 7 + s;
    return h[0] ^ h[4] ^ h[9];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge spi_sck) falls <= falls + 1;
  always @(negedge spi_cs_n) begin #1; fall_base = falls; cs_fall_cyc = cyc; end
  assign spi_miso = sbit(falls - fall_base, seed);

  always @(posedge spi_sck) begin
    #1;
    rises++;
    if (exp_q.size() == 0) mosi_err++;
    else if (spi_mosi !== exp_q.pop_front()) mosi_err++;
    if (spi_cs_n !== 1'b0) mosi_err++;
    if (last_rise < cs_fall_cyc) begin
      if (cyc - cs_fall_cyc != DIV) lead_err++;
    end else if (cyc - last_rise != DIV) per_err++;
    last_rise = cyc;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_write(logic [31:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic check_rbuf(string tag);
    logic [31:0] v;
    int bad = 0;
    logic [31:0] bv = 0, be = 0;
    for (int i = 0; i < 128; i++) begin
      bus_read(32'h1080 + i, v);
      if (v !== rm[i]) begin bad++; bv = v; be = rm[i]; end
    end
    chk(bad == 0, tag, bv, be);
  endtask

  task automatic run_xfer(int n, int sd, bit restart, string tag);
    logic [31:0] v;
    int t, r0, e0, p0, l0;
    t = (n + 1) * 8;
    seed = sd;
    for (int k = 0; k < t; k++) exp_q.push_back(wm[k / 32][31 - (k % 32)]);
    r0 = rises; e0 = mosi_err; p0 = per_err; l0 = lead_err;
    bus_write(32'h1, n);
    bus_read(32'h1, v);
    chk(v == 32'h1, {tag, " R4 busy during transfer"}, v, 1);
    if (restart) begin
      repeat (10) @(negedge clk);
      bus_write(32'h1, 32'h1FF);
    end
    @(posedge spi_cs_n);
    #1;
    chk(cyc - last_rise == DIV / 2, {tag, " R3 select rises after last fall"}, cyc - last_rise, DIV / 2);
    chk(rises - r0 == t, {tag, restart ? " R9 restart ignored, R3 pulse count" : " R3 pulse count"}, rises - r0, t);
    chk(mosi_err == e0 && exp_q.size() == 0, {tag, " R5 data-out order"}, mosi_err - e0, 0);
    chk(per_err == p0, {tag, " R10 clock period"}, per_err - p0, 0);
    chk(lead_err == l0, {tag, " R3 lead time"}, lead_err - l0, 0);
    for (int k = 0; k < t; k++) rm[k / 32][31 - (k % 32)] = sbit(k, sd);
    exp_q.delete();
    @(negedge clk);
    bus_read(32'h1, v);
    chk(v == 0, {tag, " R4 busy clears"}, v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 idle outputs", {spi_cs_n, spi_sck}, 2);
    bus_read(32'h1, v);    chk(v == 0, "R1 busy after reset", v, 0);
    bus_read(32'h1000, v); chk(v == 0, "R1 transmit word 0", v, 0);
    bus_read(32'h10FF, v); chk(v == 0, "R1 receive word 127", v, 0);
    for (int i = 0; i < 128; i++) rm[i] = 0;

    for (int i = 0; i < 128; i++) begin
      wm[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      bus_write(32'h1000 + i, wm[i]);
    end
    bus_read(32'h1000, v); chk(v == wm[0], "R2 readback word 0", v, wm[0]);
    bus_read(32'h1001, v); chk(v == wm[1], "R2 readback word 1", v, wm[1]);
    bus_read(32'h1040, v); chk(v == wm[64], "R2 readback word 64", v, wm[64]);
    bus_read(32'h107F, v); chk(v == wm[127], "R2 readback word 127", v, wm[127]);

    bus_write(32'h1085, 32'hFFFFFFFF);
    bus_read(32'h1085, v); chk(v == 0, "R8 receive write ignored", v, 0);
    bus_read(32'h1005, v); chk(v == wm[5], "R8 transmit word untouched", v, wm[5]);

    run_xfer(511, 3, 0, "full");
    check_rbuf("R6 full receive buffer");

    run_xfer(0, 11, 0, "short");
    check_rbuf("R7 short transfer keeps old bits");
    bus_read(32'h1081, v); chk(v == rm[1], "R7 word 1 untouched", v, rm[1]);

    run_xfer(2, 5, 1, "restart");
    check_rbuf("R9 receive after ignored start");

    for (int i = 0; i < 10; i++) begin
      wm[i] = ~wm[i] + i;
      bus_write(32'h1000 + i, wm[i]);
    end
    run_xfer(36, 7, 0, "mid");
    check_rbuf("R6 mid-length receive");

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule